// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the software-facing register front end of a 24-input interrupt redirection controller. Software uses two locations. It first writes an 8-bit select value, then reads or writes a 32-bit data window. Depending on the select value, the window reaches one of the following:

- the controller ID;
- a read-only version word;
- an arbitration word that mirrors the ID;
- one 32-bit half of a 64-bit redirection entry.

A third location forwards end-of-interrupt vectors to the acknowledge logic. This happens only on controller revisions that support it.

The block owns the redirection table. The delivery logic reports two status bits per entry, and the block merges them in: the remote-request flag and the delivery-in-progress flag. Software can never overwrite either bit. A write to an entry raises three outputs in a fixed order. A routing-update strobe and an EOI-counter clear come first. A service request for the same pin follows one cycle later. This lets downstream logic commit the new destination and vector before any pending level interrupt is redelivered.

The bus is a plain single-cycle port with no back-pressure. A write completes at the clock edge where `bus_wr` is high. Read data is returned with `rd_valid` exactly one cycle after `bus_rd`. The requester must accept it then, because there is no ready input. Table contents are exported in full on `entries_o`.

Top module: `irq_route_regs`

## Requirements
- R1: Only `bus_addr[7:0]` is decoded. Offset 0x00 is the 8-bit select register, readable and writable at any size. Offset 0x10 is the data window and offset 0x40 is the EOI port. A read of any other offset returns 0. Read data appears on `rd_data`, with `rd_valid` high, in the cycle after `bus_rd`.
- R2: A window access whose `bus_size` is not 4 is ignored. Such a read returns 0, and such a write changes no state and raises no strobe.
- R3: A select value S of 0x10 or above reaches entry (S − 0x10) >> 1. An odd S reaches bits 63:32 and an even S reaches bits 31:0.
- R4: A select value whose entry index is 24 or more reads as 0. A window write with such a select is ignored and raises no strobe.
- R5: Select 0x00 (ID) and select 0x02 (arbitration) both read back the 4-bit ID in bits 27:24, with all other bits 0. A write to select 0x00 stores only bits 27:24. Writes to select 0x01 and select 0x02 are ignored.
- R6: Select 0x01 reads as the VERSION parameter ORed with 23 << 16. VERSION is 0x20 or 0x11.
- R7: Entry bit 12 (delivery status) follows `dlv_stat` for that pin, delayed by one cycle. Entry bit 14 (remote request) is set by `rirr_set` and cleared by `rirr_clr`. A window write never changes either bit.
- R8: After a write to an entry, if entry bit 15 (trigger mode) is 0, meaning edge, then bit 14 is 0.
- R9: An accepted entry write raises `route_upd` and `eoi_cnt_clr` for one cycle, with `route_pin` set to the entry index, in the cycle after the write. In the next cycle it raises `svc_req` with `svc_pin` set to the same index.
- R10: A 4-byte write to offset 0x40 raises `eoi_valid` for one cycle in the following cycle, with `eoi_vector` = `bus_wdata[7:0]`. This happens only when VERSION is 0x20. Otherwise the write is ignored.
- R11: After reset, the select register and the ID are 0. Every entry is 0x0000_0000_0001_0000, which is masked (bit 16) with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write request, completes this cycle |
| bus_rd | input | 1 | Read request, data next cycle |
| bus_addr | input | ADDR_W | Byte address, low 8 bits decoded |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| rirr_set | input | NPINS | Per-pin remote-request set pulse |
| rirr_clr | input | NPINS | Per-pin remote-request clear pulse |
| dlv_stat | input | NPINS | Per-pin delivery-in-progress level |
| route_upd | output | 1 | Routing-update strobe |
| eoi_cnt_clr | output | 1 | Clear the successive-EOI counter of route_pin |
| route_pin | output | IDX_W | Entry index of the update strobe |
| svc_req | output | 1 | Service request to the delivery logic |
| svc_pin | output | IDX_W | Entry index of the service request |
| eoi_valid | output | 1 | EOI vector forwarded |
| eoi_vector | output | 8 | EOI vector |
| entries_o | output | NPINS*64 | Full redirection table, entry p at bits 64p+63:64p |

## Verification
Some behaviours are checked by assertions on every cycle:

- a routing-update strobe is always followed by a service request for the same pin, and no service request appears without one;
- an edge-mode entry just written never shows a set remote-request flag;
- an EOI pulse has a qualifying 4-byte write behind it;
- reads answer one cycle later, and short window reads answer zero.

The bench scenarios show the remaining behaviours:

- where each select value lands, and which half of an entry it reaches;
- that the read-only bits survive writes;
- that out-of-range indices and short writes are ignored;
- that the ID field is isolated;
- the version word.

A second instance with the older revision shows that the EOI port is dead there.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int ENTRY_W = 64;
  localparam int WORD_W  = 32;

  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;
  localparam logic [7:0] OFS_EOI = 8'h40;

  localparam logic [7:0] SEL_ID       = 8'h00;
  localparam logic [7:0] SEL_VER      = 8'h01;
  localparam logic [7:0] SEL_ARB      = 8'h02;
  localparam logic [7:0] SEL_TBL_BASE = 8'h10;

  localparam int BIT_DLV  = 12;
  localparam int BIT_RIRR = 14;
  localparam int BIT_TRIG = 15;
  localparam int BIT_MASK = 16;

  localparam int ID_LSB = 24;
  localparam int ID_W   = 4;

  localparam logic [ENTRY_W-1:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_ID,
    TGT_VER,
    TGT_ARB,
    TGT_ENTRY
  } win_tgt_e;

  typedef struct packed {
    win_tgt_e   tgt;
    logic       hi;
    logic [7:0] idx;
  } win_dec_t;
endpackage

// File: rtl/irq_route_windec.sv
module irq_route_windec
  import irq_route_pkg::*;
#(
  parameter int NPINS = 24
) (
  input  logic [7:0] sel,
  output win_dec_t   dec
);
  logic [7:0] off;

  always_comb begin
    off     = sel - SEL_TBL_BASE;
    dec.tgt = TGT_NONE;
    dec.hi  = 1'b0;
    dec.idx = 8'd0;
    case (sel)
      SEL_ID:  dec.tgt = TGT_ID;
      SEL_VER: dec.tgt = TGT_VER;
      SEL_ARB: dec.tgt = TGT_ARB;
      default: begin
        if (sel >= SEL_TBL_BASE) begin
          dec.idx = {1'b0, off[7:1]};
          dec.hi  = off[0];
          if (int'(dec.idx) < NPINS) dec.tgt = TGT_ENTRY;
        end
      end
    endcase
  end
endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_route_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_hi,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               rirr_set,
  input  logic               rirr_clr,
  input  logic               dlv_stat,
  output logic [ENTRY_W-1:0] entry_o
);
  logic [ENTRY_W-1:0] ent_q, ent_n;

  always_comb begin
    ent_n = ent_q;
    if (wr_en) begin
      if (wr_hi) ent_n[ENTRY_W-1:WORD_W] = wdata;
      else       ent_n[WORD_W-1:0]       = wdata;
    end
    // status bits are owned by the delivery side, never by software
    ent_n[BIT_DLV]  = dlv_stat;
    ent_n[BIT_RIRR] = (ent_q[BIT_RIRR] & ~rirr_clr) | rirr_set;
    // an edge-mode entry carries no outstanding remote request
    if (wr_en && !ent_n[BIT_TRIG]) ent_n[BIT_RIRR] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_q <= ENTRY_RST;
    else        ent_q <= ent_n;
  end

  assign entry_o = ent_q;
endmodule

// File: rtl/irq_route_rdmux.sv
module irq_route_rdmux
  import irq_route_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h20,
  localparam int        IDX_W   = $clog2(NPINS)
) (
  input  win_dec_t                       dec,
  input  logic [ID_W-1:0]                id,
  input  logic [NPINS-1:0][ENTRY_W-1:0]  entries,
  output logic [WORD_W-1:0]              word
);
  localparam logic [WORD_W-1:0] VER_WORD =
    WORD_W'(VERSION) | (WORD_W'(NPINS - 1) << 16);

  logic [ENTRY_W-1:0] picked;

  always_comb begin
    picked = entries[dec.idx[IDX_W-1:0]];
    case (dec.tgt)
      TGT_ID, TGT_ARB: word = WORD_W'(id) << ID_LSB;
      TGT_VER:         word = VER_WORD;
      TGT_ENTRY:       word = dec.hi ? picked[ENTRY_W-1:WORD_W] : picked[WORD_W-1:0];
      default:         word = '0;
    endcase
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h20,
  parameter int         ADDR_W  = 12,
  localparam int        IDX_W   = $clog2(NPINS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [2:0]                 bus_size,
  input  logic [31:0]                bus_wdata,
  output logic                       rd_valid,
  output logic [31:0]                rd_data,
  input  logic [NPINS-1:0]           rirr_set,
  input  logic [NPINS-1:0]           rirr_clr,
  input  logic [NPINS-1:0]           dlv_stat,
  output logic                       route_upd,
  output logic                       eoi_cnt_clr,
  output logic [IDX_W-1:0]           route_pin,
  output logic                       svc_req,
  output logic [IDX_W-1:0]           svc_pin,
  output logic                       eoi_valid,
  output logic [7:0]                 eoi_vector,
  output logic [NPINS*ENTRY_W-1:0]   entries_o
);
  localparam bool_eoi_ok = (VERSION == 8'h20);

  logic [7:0]      ofs;
  logic            full_word;
  logic [7:0]      sel_q;
  logic [ID_W-1:0] id_q;
  win_dec_t        dec;
  logic            win_wr, ent_wr, id_wr, sel_wr, eoi_wr;
  logic [WORD_W-1:0] win_word;
  logic [NPINS-1:0][ENTRY_W-1:0] ent_arr;
  logic            unused_addr_hi;

  assign ofs            = bus_addr[7:0];
  assign unused_addr_hi = ^bus_addr;
  assign full_word      = (bus_size == 3'd4);

  irq_route_windec #(.NPINS(NPINS)) u_dec (
    .sel (sel_q),
    .dec (dec)
  );

  assign sel_wr = bus_wr && (ofs == OFS_SEL);
  assign win_wr = bus_wr && (ofs == OFS_WIN) && full_word;
  assign ent_wr = win_wr && (dec.tgt == TGT_ENTRY);
  assign id_wr  = win_wr && (dec.tgt == TGT_ID);
  assign eoi_wr = bus_wr && (ofs == OFS_EOI) && full_word && bool_eoi_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_wr) sel_q <= bus_wdata[7:0];
      if (id_wr)  id_q  <= bus_wdata[ID_LSB +: ID_W];
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_ent
    irq_route_entry u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ent_wr && (dec.idx == 8'(p))),
      .wr_hi    (dec.hi),
      .wdata    (bus_wdata),
      .rirr_set (rirr_set[p]),
      .rirr_clr (rirr_clr[p]),
      .dlv_stat (dlv_stat[p]),
      .entry_o  (ent_arr[p])
    );
  end

  assign entries_o = ent_arr;

  irq_route_rdmux #(.NPINS(NPINS), .VERSION(VERSION)) u_rd (
    .dec     (dec),
    .id      (id_q),
    .entries (ent_arr),
    .word    (win_word)
  );

  // update strobe first, service request one cycle behind it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_upd  <= 1'b0;
      route_pin  <= '0;
      svc_req    <= 1'b0;
      svc_pin    <= '0;
      eoi_valid  <= 1'b0;
      eoi_vector <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      route_upd  <= ent_wr;
      if (ent_wr) route_pin <= dec.idx[IDX_W-1:0];
      svc_req    <= route_upd;
      if (route_upd) svc_pin <= route_pin;
      eoi_valid  <= eoi_wr;
      if (eoi_wr) eoi_vector <= bus_wdata[7:0];
      rd_valid   <= bus_rd;
      if (bus_rd) begin
        case (ofs)
          OFS_SEL: rd_data <= {24'd0, sel_q};
          OFS_WIN: rd_data <= full_word ? win_word : '0;
          default: rd_data <= '0;
        endcase
      end
    end
  end

  assign eoi_cnt_clr = route_upd;
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NPINS  = 24,
  parameter int ADDR_W = 12,
  localparam int IDX_W = $clog2(NPINS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [2:0]            bus_size,
  input logic [31:0]           rd_data,
  input logic                  rd_valid,
  input logic                  route_upd,
  input logic [IDX_W-1:0]      route_pin,
  input logic                  svc_req,
  input logic [IDX_W-1:0]      svc_pin,
  input logic                  eoi_valid,
  input logic [NPINS*64-1:0]   entries_o
);
  // R9
  upd_then_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route_upd |=> (svc_req && svc_pin == $past(route_pin)));

  // R9
  svc_needs_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> $past(route_upd));

  // R8
  edge_rirr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route_upd |-> !(!entries_o[int'(route_pin)*64 + 15] && entries_o[int'(route_pin)*64 + 14]));

  // R10
  eoi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> ($past(bus_wr) && $past(bus_addr[7:0]) == 8'h40 && $past(bus_size) == 3'd4));

  // R1
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid);

  // R2
  short_win_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[7:0] == 8'h10 && bus_size != 3'd4) |=> (rd_data == 32'd0));
endmodule

bind irq_route_regs irq_route_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .route_upd (route_upd),
  .route_pin (route_pin),
  .svc_req   (svc_req),
  .svc_pin   (svc_pin),
  .eoi_valid (eoi_valid),
  .entries_o (entries_o)
);

// File: tb/sim_irq_route_regs.sv
module sim_irq_route_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;
  localparam int IW = $clog2(NP);
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [2:0]  bus_size = 3'd4;
  logic [31:0] bus_wdata = '0;
  logic [NP-1:0] rirr_set = '0, rirr_clr = '0, dlv_stat = '0;

  logic rd_valid, route_upd, eoi_cnt_clr, svc_req, eoi_valid;
  logic [31:0] rd_data;
  logic [IW-1:0] route_pin, svc_pin;
  logic [7:0] eoi_vector;
  logic [NP*64-1:0] entries_o;

  logic b_rd_valid, b_route_upd, b_eoi_cnt_clr, b_svc_req, b_eoi_valid;
  logic [31:0] b_rd_data;
  logic [IW-1:0] b_route_pin, b_svc_pin;
  logic [7:0] b_eoi_vector;
  logic [NP*64-1:0] b_entries_o;

  int n_checks = 0, n_fail = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_regs #(.NPINS(NP), .VERSION(8'h20), .ADDR_W(12)) u0 (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_size, .bus_wdata,
    .rd_valid, .rd_data, .rirr_set, .rirr_clr, .dlv_stat,
    .route_upd, .eoi_cnt_clr, .route_pin, .svc_req, .svc_pin,
    .eoi_valid, .eoi_vector, .entries_o);

  irq_route_regs #(.NPINS(NP), .VERSION(8'h11), .ADDR_W(12)) u1 (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_size, .bus_wdata,
    .rd_valid(b_rd_valid), .rd_data(b_rd_data), .rirr_set, .rirr_clr, .dlv_stat,
    .route_upd(b_route_upd), .eoi_cnt_clr(b_eoi_cnt_clr), .route_pin(b_route_pin),
    .svc_req(b_svc_req), .svc_pin(b_svc_pin), .eoi_valid(b_eoi_valid),
    .eoi_vector(b_eoi_vector), .entries_o(b_entries_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [11:0] a, input logic [2:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_size = 3'd4;
  endtask

  task automatic bread(input logic [11:0] a, input logic [2:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_size = sz;
    @(negedge clk);
    d = rd_data;
    bus_rd = 1'b0; bus_size = 3'd4;
  endtask

  task automatic rd_entry(input logic [7:0] s, output logic [31:0] d);
    bwrite(12'h000, 3'd4, {24'd0, s});
    bread(12'h010, 3'd4, d);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R11 route_upd idle", {31'd0, route_upd}, 32'd0);
    bread(12'h000, 3'd4, d);
    chk("R11 select reset", d, 32'd0);
    bread(12'h010, 3'd4, d);
    chk("R11 id reset", d, 32'd0);
    rd_entry(8'h10, d);
    chk("R11 entry0 low masked", d, 32'h0001_0000);
    rd_entry(8'h3F, d);
    chk("R11 entry23 high", d, 32'd0);
  endtask

  task automatic t_id_ver;
    logic [31:0] d;
    bwrite(12'h000, 3'd4, 32'h0);
    bwrite(12'h010, 3'd4, 32'hFFFF_FFFF);
    bread(12'h010, 3'd4, d);
    chk("R5 id field only", d, 32'h0F00_0000);
    bwrite(12'h000, 3'd4, 32'h2);
    bwrite(12'h010, 3'd4, 32'h0);
    bread(12'h010, 3'd4, d);
    chk("R5 arb mirrors id, write ignored", d, 32'h0F00_0000);
    bwrite(12'h000, 3'd4, 32'h1);
    bwrite(12'h010, 3'd4, 32'h0);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 12'h010;
    @(negedge clk);
    chk("R6 version 0x20", rd_data, 32'h0017_0020);
    chk("R6 version 0x11", b_rd_data, 32'h0017_0011);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd1);
    bus_rd = 1'b0;
  endtask

  task automatic t_entry;
    logic [31:0] d;
    bwrite(12'h000, 3'd4, 32'h12);
    bwrite(12'h010, 3'd4, 32'h0000_A031);
    chk("R9 route_upd", {31'd0, route_upd}, 32'd1);
    chk("R9 route_pin", 32'(route_pin), 32'd1);
    chk("R9 cnt_clr", {31'd0, eoi_cnt_clr}, 32'd1);
    chk("R9 svc not yet", {31'd0, svc_req}, 32'd0);
    @(negedge clk);
    chk("R9 svc_req after update", {31'd0, svc_req}, 32'd1);
    chk("R9 svc_pin", 32'(svc_pin), 32'd1);
    chk("R9 update single pulse", {31'd0, route_upd}, 32'd0);
    bread(12'h010, 3'd4, d);
    chk("R3 pin1 low", d, 32'h0000_A031);
    bwrite(12'h000, 3'd4, 32'h13);
    bwrite(12'h010, 3'd4, 32'hAB00_0000);
    bread(12'h010, 3'd4, d);
    chk("R3 pin1 high", d, 32'hAB00_0000);
    chk("R3 high in table", entries_o[1*64+32 +: 32], 32'hAB00_0000);
    bwrite(12'h000, 3'd4, 32'h3F);
    bwrite(12'h010, 3'd4, 32'h5500_0000);
    chk("R3 pin23 strobe", 32'(route_pin), 32'd23);
    bread(12'h010, 3'd4, d);
    chk("R3 pin23 high", d, 32'h5500_0000);
  endtask

  task automatic t_status;
    logic [31:0] d;
    @(negedge clk); rirr_set[1] = 1'b1;
    @(negedge clk); rirr_set[1] = 1'b0;
    rd_entry(8'h12, d);
    chk("R7 rirr set by pulse", d, 32'h0000_E031);
    bwrite(12'h010, 3'd4, 32'h0000_A032);
    bread(12'h010, 3'd4, d);
    chk("R7 rirr kept on level write", d, 32'h0000_E032);
    bwrite(12'h010, 3'd4, 32'h0000_5032);
    bread(12'h010, 3'd4, d);
    chk("R8 edge write clears rirr", d, 32'h0000_0032);
    dlv_stat[1] = 1'b1;
    bread(12'h010, 3'd4, d);
    chk("R7 delivery status mirror", d, 32'h0000_1032);
    bwrite(12'h010, 3'd4, 32'h0000_C032);
    bread(12'h010, 3'd4, d);
    chk("R7 status bits not writable", d, 32'h0000_9032);
    dlv_stat[1] = 1'b0;
    @(negedge clk); rirr_set[1] = 1'b1;
    @(negedge clk); rirr_set[1] = 1'b0; rirr_clr[1] = 1'b1;
    @(negedge clk); rirr_clr[1] = 1'b0;
    bread(12'h010, 3'd4, d);
    chk("R7 rirr clear pulse", d, 32'h0000_8032);
  endtask

  task automatic t_range_size;
    logic [31:0] d;
    bwrite(12'h000, 3'd4, 32'h40);
    bwrite(12'h010, 3'd4, 32'h0000_1234);
    chk("R4 no strobe out of range", {31'd0, route_upd}, 32'd0);
    bread(12'h010, 3'd4, d);
    chk("R4 index 24 reads zero", d, 32'd0);
    rd_entry(8'h41, d);
    chk("R4 index 24 high zero", d, 32'd0);
    rd_entry(8'h10, d);
    bwrite(12'h010, 3'd2, 32'h0);
    chk("R2 short write no strobe", {31'd0, route_upd}, 32'd0);
    bread(12'h010, 3'd4, d);
    chk("R2 short write ignored", d, 32'h0001_0000);
    bread(12'h010, 3'd2, d);
    chk("R2 short read zero", d, 32'd0);
  endtask

  task automatic t_addr;
    logic [31:0] d;
    bwrite(12'hF00, 3'd1, 32'h0000_0002);
    bread(12'h300, 3'd1, d);
    chk("R1 upper bits ignored, select byte", d, 32'h2);
    bread(12'h020, 3'd4, d);
    chk("R1 unmapped offset zero", d, 32'd0);
  endtask

  task automatic t_eoi;
    bwrite(12'h040, 3'd4, 32'h0000_0121);
    chk("R10 eoi valid", {31'd0, eoi_valid}, 32'd1);
    chk("R10 eoi vector", {24'd0, eoi_vector}, 32'h21);
    chk("R10 old revision ignores eoi", {31'd0, b_eoi_valid}, 32'd0);
    bwrite(12'h040, 3'd2, 32'h0000_0033);
    chk("R10 short eoi ignored", {31'd0, eoi_valid}, 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_id_ver();
    t_entry();
    t_status();
    t_range_size();
    t_addr();
    t_eoi();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule